// File: doc/BRIEF.md
# Head Step Sequencer

This block moves the read/write heads of up to four disk drives. It receives commands that are already decoded: a timing setup, a move to a given cylinder, a return to cylinder zero, and a request for the result of the last move. It keeps the current cylinder of each drive. It produces step pulses at a programmed interval together with a direction level, and it counts the interval in ticks of an external millisecond strobe.

When a move ends, the block composes an 8-bit completion status and raises an interrupt. The interrupt stays high until the host asks for the result. That request returns the status byte and the current cylinder of the drive that finished. The setup command also holds the head settle and release delays and a transfer-mode flag, which later stages of the controller read from the outputs.

Top module: `head_step_seq`

## Requirements
- R1: On a setup command, `cmd_arg0_i[7:4]` (R) gives a step interval of 16−R ms, so 0 gives 16 ms. `cmd_arg0_i[3:0]` (U) gives a release delay of U×16 ms, with 0 giving 256. `cmd_arg1_i[7:1]` (L) gives a settle delay of L×2 ms, with 0 giving 256. `cmd_arg1_i[0]` is the transfer-mode flag. After reset all four fields are zero.
- R2: Each step pulse is high for exactly one clock. It rises in the cycle after the millisecond tick that ends the interval. Successive pulses of one move are exactly one step interval of ticks apart.
- R3: For a move command (op 1), `dir_o` is 1 when the target in `cmd_arg0_i` is greater than the current cylinder and 0 otherwise. The current cylinder changes by one on every pulse. The number of pulses equals the distance to the target.
- R4: A move whose target equals the current cylinder produces no pulses and still completes with the seek-end bit set.
- R5: A return-to-zero command (op 2) steps with `dir_o`=0. It samples `trk0_i` before each step, and when `trk0_i` is high it ends normally with the cylinder set to 0.
- R6: If `trk0_i` has not been seen after 77 pulses, the return-to-zero ends with status bits 7..6 = 01 (abnormal) and bit 4 (equipment check) set.
- R7: `fault_i` high at a step decision ends the move at once with status bits 7..6 = 01 and bit 4 set. No further pulses follow.
- R8: The status byte is laid out as follows: bits 7..6 hold the termination code (00 normal, 01 abnormal, 10 invalid), bit 5 is seek end (set at every move completion), bit 4 is equipment check, bit 3 is 0, bit 2 is the head (always 0 for return-to-zero) and bits 1..0 are the drive.
- R9: While a move runs, `busy_o` has exactly the bit of the moving drive set and `cmd_ready_o` is low. At idle, `busy_o` is zero.
- R10: `irq_o` rises at the completion of a move and stays high until a result request (op 3). That request pulses `sense_valid_o` for one cycle with the status byte and the current cylinder of the finished drive, and it clears `irq_o`.
- R11: A result request with no interrupt pending returns status 0x80 and cylinder 0.
- R12: Each drive keeps its own cylinder. A move of one drive leaves the cylinders of the other drives unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| ms_tick_i | input | 1 | One-cycle strobe once per millisecond |
| cmd_valid_i | input | 1 | Command present |
| cmd_op_i | input | 2 | 0 setup, 1 move, 2 return to zero, 3 result request |
| cmd_unit_i | input | 2 | Target drive |
| cmd_head_i | input | 1 | Head reported in status for a move |
| cmd_arg0_i | input | 8 | Setup byte 0, or move target cylinder |
| cmd_arg1_i | input | 8 | Setup byte 1 |
| cmd_ready_o | output | 1 | Idle, command accepted when valid |
| trk0_i | input | 1 | Selected drive is at cylinder zero |
| fault_i | input | 1 | Selected drive reports a fault |
| step_o | output | 1 | Step pulse |
| dir_o | output | 1 | 1 inward, 0 outward |
| drv_sel_o | output | 2 | Drive being moved |
| busy_o | output | 4 | Per-drive moving flag |
| irq_o | output | 1 | Completion pending |
| sense_valid_o | output | 1 | Result output valid |
| sense_st0_o | output | 8 | Status byte |
| sense_pcn_o | output | 8 | Current cylinder of the reporting drive |
| head_load_ms_o | output | 9 | Head settle delay in ms |
| head_unload_ms_o | output | 9 | Head release delay in ms |
| non_dma_o | output | 1 | Transfer-mode flag |

## Verification
The bench measures the gap between consecutive pulses in ticks. A decode of the rate nibble that is off by one, or inverted, shows up there as a wrong interval. It runs a return to zero that never sees track zero and counts exactly 77 pulses. A limit compare that is off by one gives 76 or 78 pulses and a wrong leftover cylinder. A move to the current cylinder must still interrupt with seek end set; a design that waits for a first step would hang at that point. The bench raises a fault partway through a move, which catches a design that keeps stepping or loses the cylinder count. It also checks that other drives keep their cylinders, which catches a design that shares one cylinder register.

// File: rtl/head_step_pkg.sv
package head_step_pkg;
  typedef enum logic [1:0] {
    OP_SPECIFY = 2'd0,
    OP_SEEK    = 2'd1,
    OP_RECAL   = 2'd2,
    OP_SENSE   = 2'd3
  } op_e;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_EVAL = 2'd1,
    ST_WAIT = 2'd2
  } state_e;

  localparam logic [1:0] TERM_OK  = 2'b00;
  localparam logic [1:0] TERM_ABN = 2'b01;
  localparam logic [1:0] TERM_INV = 2'b10;

  function automatic logic [7:0] mk_st0(logic [1:0] term, logic se, logic ec,
                                        logic hd, logic [1:0] un);
    return {term, se, ec, 1'b0, hd, un};
  endfunction
endpackage

// File: rtl/head_step_timing.sv
module head_step_timing #(
  parameter int STEP_W = 5,
  parameter int DLY_W  = 9
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic [7:0]        arg0_i,
  input  logic [7:0]        arg1_i,
  output logic [STEP_W-1:0] step_ms_o,
  output logic [DLY_W-1:0]  load_ms_o,
  output logic [DLY_W-1:0]  unload_ms_o,
  output logic              non_dma_o
);
  logic [3:0] rate_q, rel_q;
  logic [6:0] settle_q;
  logic       nd_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rate_q   <= '0;
      rel_q    <= '0;
      settle_q <= '0;
      nd_q     <= 1'b0;
    end else if (we_i) begin
      rate_q   <= arg0_i[7:4];
      rel_q    <= arg0_i[3:0];
      settle_q <= arg1_i[7:1];
      nd_q     <= arg1_i[0];
    end
  end

  // higher rate code means shorter interval; code 0 is the slowest
  assign step_ms_o   = STEP_W'(16) - STEP_W'(rate_q);
  assign load_ms_o   = (settle_q == '0) ? DLY_W'(256) : DLY_W'({settle_q, 1'b0});
  assign unload_ms_o = (rel_q == '0) ? DLY_W'(256) : DLY_W'({rel_q, 4'b0000});
  assign non_dma_o   = nd_q;
endmodule

// File: rtl/head_step_timer.sv
module head_step_timer #(
  parameter int W = 5
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         load_i,
  input  logic [W-1:0] val_i,
  input  logic         tick_i,
  output logic         expire_o
);
  logic [W-1:0] cnt_q;
  logic         run_q;

  assign expire_o = run_q && tick_i && (cnt_q == W'(1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      run_q <= 1'b0;
    end else if (load_i) begin
      cnt_q <= val_i;
      run_q <= 1'b1;
    end else if (run_q && tick_i) begin
      if (cnt_q == W'(1)) run_q <= 1'b0;
      else                cnt_q <= cnt_q - W'(1);
    end
  end
endmodule

// File: rtl/head_step_cyl_bank.sv
module head_step_cyl_bank #(
  parameter int N_DRIVES = 4,
  parameter int CYL_W    = 8
) (
  input  logic                            clk_i,
  input  logic                            rst_ni,
  input  logic                            we_i,
  input  logic [1:0]                      wa_i,
  input  logic [CYL_W-1:0]                wd_i,
  output logic [N_DRIVES-1:0][CYL_W-1:0]  cyl_o
);
  for (genvar i = 0; i < N_DRIVES; i++) begin : g_drv
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                       cyl_o[i] <= '0;
      else if (we_i && wa_i == 2'(i))    cyl_o[i] <= wd_i;
    end
  end
endmodule

// File: rtl/head_step_seq.sv
module head_step_seq
  import head_step_pkg::*;
#(
  parameter int N_DRIVES    = 4,
  parameter int CYL_W       = 8,
  parameter int RECAL_LIMIT = 77,
  parameter int STEP_W      = 5,
  parameter int DLY_W       = 9
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                ms_tick_i,
  input  logic                cmd_valid_i,
  input  logic [1:0]          cmd_op_i,
  input  logic [1:0]          cmd_unit_i,
  input  logic                cmd_head_i,
  input  logic [7:0]          cmd_arg0_i,
  input  logic [7:0]          cmd_arg1_i,
  output logic                cmd_ready_o,
  input  logic                trk0_i,
  input  logic                fault_i,
  output logic                step_o,
  output logic                dir_o,
  output logic [1:0]          drv_sel_o,
  output logic [N_DRIVES-1:0] busy_o,
  output logic                irq_o,
  output logic                sense_valid_o,
  output logic [7:0]          sense_st0_o,
  output logic [CYL_W-1:0]    sense_pcn_o,
  output logic [DLY_W-1:0]    head_load_ms_o,
  output logic [DLY_W-1:0]    head_unload_ms_o,
  output logic                non_dma_o
);
  localparam int NS_W = $clog2(RECAL_LIMIT + 1);
  localparam logic [CYL_W-1:0] CYL_MAX = '1;

  state_e                         state_q;
  logic [1:0]                     unit_q;
  logic                           head_q, recal_q, dir_q, step_q, irq_q;
  logic [CYL_W-1:0]               tgt_q;
  logic [NS_W-1:0]                nsteps_q;
  logic [7:0]                     pend_st0_q;
  logic [1:0]                     pend_unit_q;
  logic                           sv_q;
  logic [7:0]                     sst0_q;
  logic [CYL_W-1:0]               spcn_q;

  logic [N_DRIVES-1:0][CYL_W-1:0] cyl_all;
  logic [CYL_W-1:0]               cur;
  logic [STEP_W-1:0]              step_ms;
  logic                           accept, spec_we, tmr_load, tmr_exp;
  logic                           cyl_we, fin, fin_ec, dir_d;
  logic [CYL_W-1:0]               cyl_wd;

  assign accept  = (state_q == ST_IDLE) && cmd_valid_i;
  assign spec_we = accept && (op_e'(cmd_op_i) == OP_SPECIFY);
  assign cur     = cyl_all[unit_q];

  head_step_timing #(.STEP_W(STEP_W), .DLY_W(DLY_W)) u_timing (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .we_i        (spec_we),
    .arg0_i      (cmd_arg0_i),
    .arg1_i      (cmd_arg1_i),
    .step_ms_o   (step_ms),
    .load_ms_o   (head_load_ms_o),
    .unload_ms_o (head_unload_ms_o),
    .non_dma_o   (non_dma_o)
  );

  head_step_timer #(.W(STEP_W)) u_timer (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .load_i   (tmr_load),
    .val_i    (step_ms),
    .tick_i   (ms_tick_i),
    .expire_o (tmr_exp)
  );

  head_step_cyl_bank #(.N_DRIVES(N_DRIVES), .CYL_W(CYL_W)) u_cyl (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .we_i   (cyl_we),
    .wa_i   (unit_q),
    .wd_i   (cyl_wd),
    .cyl_o  (cyl_all)
  );

  // step decision: fault first, then track zero / step limit / target reached
  always_comb begin
    tmr_load = 1'b0;
    cyl_we   = 1'b0;
    cyl_wd   = cur;
    fin      = 1'b0;
    fin_ec   = 1'b0;
    dir_d    = dir_q;
    unique case (state_q)
      ST_EVAL: begin
        if (fault_i) begin
          fin    = 1'b1;
          fin_ec = 1'b1;
        end else if (recal_q) begin
          if (trk0_i) begin
            fin    = 1'b1;
            cyl_we = 1'b1;
            cyl_wd = '0;
          end else if (nsteps_q == NS_W'(RECAL_LIMIT)) begin
            fin    = 1'b1;
            fin_ec = 1'b1;
          end else begin
            tmr_load = 1'b1;
            dir_d    = 1'b0;
          end
        end else if (cur == tgt_q) begin
          fin = 1'b1;
        end else begin
          tmr_load = 1'b1;
          dir_d    = (tgt_q > cur);
        end
      end
      ST_WAIT: begin
        if (tmr_exp) begin
          cyl_we = 1'b1;
          if (dir_q) cyl_wd = (cur == CYL_MAX) ? cur : cur + CYL_W'(1);
          else       cyl_wd = (cur == '0) ? cur : cur - CYL_W'(1);
        end
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q     <= ST_IDLE;
      unit_q      <= '0;
      head_q      <= 1'b0;
      recal_q     <= 1'b0;
      tgt_q       <= '0;
      nsteps_q    <= '0;
      dir_q       <= 1'b0;
      step_q      <= 1'b0;
      irq_q       <= 1'b0;
      pend_st0_q  <= '0;
      pend_unit_q <= '0;
      sv_q        <= 1'b0;
      sst0_q      <= '0;
      spcn_q      <= '0;
    end else begin
      step_q <= 1'b0;
      sv_q   <= 1'b0;
      dir_q  <= dir_d;
      unique case (state_q)
        ST_IDLE: begin
          if (accept) begin
            unique case (op_e'(cmd_op_i))
              OP_SEEK, OP_RECAL: begin
                unit_q   <= cmd_unit_i;
                recal_q  <= (op_e'(cmd_op_i) == OP_RECAL);
                head_q   <= (op_e'(cmd_op_i) == OP_RECAL) ? 1'b0 : cmd_head_i;
                tgt_q    <= CYL_W'(cmd_arg0_i);
                nsteps_q <= '0;
                state_q  <= ST_EVAL;
              end
              OP_SENSE: begin
                sv_q <= 1'b1;
                if (irq_q) begin
                  sst0_q <= pend_st0_q;
                  spcn_q <= cyl_all[pend_unit_q];
                  irq_q  <= 1'b0;
                end else begin
                  sst0_q <= mk_st0(TERM_INV, 1'b0, 1'b0, 1'b0, 2'b00);
                  spcn_q <= '0;
                end
              end
              default: ;
            endcase
          end
        end
        ST_EVAL: begin
          if (fin) begin
            pend_st0_q  <= mk_st0(fin_ec ? TERM_ABN : TERM_OK, 1'b1, fin_ec,
                                  head_q, unit_q);
            pend_unit_q <= unit_q;
            irq_q       <= 1'b1;
            state_q     <= ST_IDLE;
          end else begin
            state_q <= ST_WAIT;
          end
        end
        ST_WAIT: begin
          if (tmr_exp) begin
            step_q   <= 1'b1;
            nsteps_q <= (nsteps_q == '1) ? nsteps_q : nsteps_q + NS_W'(1);
            state_q  <= ST_EVAL;
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  for (genvar i = 0; i < N_DRIVES; i++) begin : g_busy
    assign busy_o[i] = (state_q != ST_IDLE) && (unit_q == 2'(i));
  end

  assign cmd_ready_o   = (state_q == ST_IDLE);
  assign step_o        = step_q;
  assign dir_o         = dir_q;
  assign drv_sel_o     = unit_q;
  assign irq_o         = irq_q;
  assign sense_valid_o = sv_q;
  assign sense_st0_o   = sst0_q;
  assign sense_pcn_o   = spcn_q;
endmodule

// File: rtl/head_step_seq_chk.sv
module head_step_seq_chk #(
  parameter int N_DRIVES = 4
) (
  input logic                clk_i,
  input logic                rst_ni,
  input logic                ms_tick_i,
  input logic                step_o,
  input logic                dir_o,
  input logic [N_DRIVES-1:0] busy_o,
  input logic                irq_o,
  input logic                sense_valid_o,
  input logic                cmd_ready_o
);
  a_r2_step_one_clk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    step_o |=> !step_o);

  a_r2_step_after_tick: assert property (@(posedge clk_i) disable iff (!rst_ni)
    step_o |-> $past(ms_tick_i));

  a_r3_dir_settled: assert property (@(posedge clk_i) disable iff (!rst_ni)
    step_o |-> $stable(dir_o));

  a_r9_busy_onehot: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(busy_o));

  a_r9_ready_low_when_busy: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o != '0) |-> !cmd_ready_o);

  a_r9_step_only_busy: assert property (@(posedge clk_i) disable iff (!rst_ni)
    step_o |-> (busy_o != '0));

  a_r10_irq_ends_move: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(irq_o) |-> ($past(busy_o) != '0) && (busy_o == '0));

  a_r10_sense_clears_irq: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sense_valid_o |-> !irq_o);
endmodule

bind head_step_seq head_step_seq_chk #(.N_DRIVES(N_DRIVES)) u_chk (
  .clk_i         (clk_i),
  .rst_ni        (rst_ni),
  .ms_tick_i     (ms_tick_i),
  .step_o        (step_o),
  .dir_o         (dir_o),
  .busy_o        (busy_o),
  .irq_o         (irq_o),
  .sense_valid_o (sense_valid_o),
  .cmd_ready_o   (cmd_ready_o)
);

// File: tb/head_step_seq_tb.sv
module head_step_seq_tb;
  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic       rst_n, ms_tick, cmd_valid, cmd_head, cmd_ready;
  logic [1:0] cmd_op, cmd_unit, drv_sel;
  logic [7:0] arg0, arg1, st0, pcn;
  logic       trk0, fault, step, dir, irq, sv, nd;
  logic [3:0] busy;
  logic [8:0] ld_ms, uld_ms;

  head_step_seq u_dut (
    .clk_i(clk), .rst_ni(rst_n), .ms_tick_i(ms_tick),
    .cmd_valid_i(cmd_valid), .cmd_op_i(cmd_op), .cmd_unit_i(cmd_unit),
    .cmd_head_i(cmd_head), .cmd_arg0_i(arg0), .cmd_arg1_i(arg1),
    .cmd_ready_o(cmd_ready), .trk0_i(trk0), .fault_i(fault),
    .step_o(step), .dir_o(dir), .drv_sel_o(drv_sel), .busy_o(busy),
    .irq_o(irq), .sense_valid_o(sv), .sense_st0_o(st0), .sense_pcn_o(pcn),
    .head_load_ms_o(ld_ms), .head_unload_ms_o(uld_ms), .non_dma_o(nd)
  );

  int n_chk = 0, n_bad = 0;
  int pulse_total = 0, ivl_bad = 0, dir_bad = 0, wide_bad = 0, tick_cnt = 0;
  int div = 0, pulse_base = 0, trk0_at = 0, fault_at = 0, exp_step = 16;
  bit prev_valid = 0, step_prev = 0, exp_dir = 0, trk0_arm = 0, fault_arm = 0;

  assign trk0  = trk0_arm  && ((pulse_total - pulse_base) >= trk0_at);
  assign fault = fault_arm && ((pulse_total - pulse_base) >= fault_at);

  task automatic check(string tag, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // pulse monitor and tick source (tick asserted every 4th clock)
  always @(negedge clk) begin
    if (ms_tick) tick_cnt++;
    if (step) begin
      pulse_total++;
      if (prev_valid && tick_cnt != exp_step) ivl_bad++;
      if (dir !== exp_dir) dir_bad++;
      prev_valid = 1;
      tick_cnt = 0;
    end
    if (step && step_prev) wide_bad++;
    step_prev = step;
    if (busy == 4'b0) begin
      prev_valid = 0;
      tick_cnt = 0;
    end
    div = (div == 3) ? 0 : div + 1;
    ms_tick <= (div == 0);
  end

  task automatic issue(logic [1:0] op, int unit, bit head, int a0, int a1);
    @(negedge clk);
    cmd_op = op; cmd_unit = 2'(unit); cmd_head = head;
    arg0 = 8'(a0); arg1 = 8'(a1); cmd_valid = 1'b1;
    @(negedge clk);
    cmd_valid = 1'b0;
  endtask

  task automatic sense_expect(string tag, int est0, int epcn);
    issue(2'd3, 0, 0, 0, 0);
    check({tag, " sense_valid"}, int'(sv), 1);
    check({tag, " st0"}, int'(st0), est0);
    check({tag, " pcn"}, int'(pcn), epcn);
    check({tag, " irq cleared"}, int'(irq), 0);
  endtask

  task automatic run_move(string tag, logic [1:0] op, int unit, bit head, int tgt,
                          bit edir, int eps, int est0, int epcn, int estep);
    int base, i0, d0, w0, to;
    exp_dir = edir; exp_step = estep;
    base = pulse_total; i0 = ivl_bad; d0 = dir_bad; w0 = wide_bad;
    issue(op, unit, head, tgt, 0);
    check({tag, " R9 busy onehot"}, int'(busy), 1 << unit);
    check({tag, " R9 ready low"}, int'(cmd_ready), 0);
    to = 0;
    while (!irq && to < 20000) begin @(negedge clk); to++; end
    check({tag, " R10 irq raised"}, int'(irq), 1);
    check({tag, " R9 busy cleared"}, int'(busy), 0);
    check({tag, " pulse count"}, pulse_total - base, eps);
    check({tag, " R2 interval"}, ivl_bad - i0, 0);
    check({tag, " R2 width"}, wide_bad - w0, 0);
    check({tag, " R3 direction"}, dir_bad - d0, 0);
    sense_expect({tag, " R8 R10"}, est0, epcn);
    trk0_arm = 0; fault_arm = 0;
  endtask

  task automatic t_reset();
    check("R9 ready after reset", int'(cmd_ready), 1);
    check("R10 irq after reset", int'(irq), 0);
    check("R9 busy after reset", int'(busy), 0);
    check("R2 step after reset", int'(step), 0);
    check("R1 load default", int'(ld_ms), 256);
    check("R1 unload default", int'(uld_ms), 256);
    check("R1 mode default", int'(nd), 0);
  endtask

  task automatic t_sense_empty();
    sense_expect("R11 empty", 8'h80, 0);
  endtask

  task automatic t_specify();
    issue(2'd0, 0, 0, 8'hD3, 8'h0B);
    check("R1 load 10", int'(ld_ms), 10);
    check("R1 unload 48", int'(uld_ms), 48);
    check("R1 mode set", int'(nd), 1);
  endtask

  task automatic t_seek_in();
    pulse_base = pulse_total;
    run_move("R3 seek in", 2'd1, 1, 1, 5, 1, 5, 8'h25, 5, 3);
  endtask

  task automatic t_seek_out();
    run_move("R3 seek out", 2'd1, 1, 0, 2, 0, 3, 8'h21, 2, 3);
  endtask

  task automatic t_seek_equal();
    run_move("R4 seek equal", 2'd1, 1, 0, 2, 0, 0, 8'h21, 2, 3);
  endtask

  task automatic t_independent();
    run_move("R12 drive0 untouched", 2'd1, 0, 0, 0, 0, 0, 8'h20, 0, 3);
  endtask

  task automatic t_recal_ok();
    run_move("R12 drive2 out", 2'd1, 2, 0, 10, 1, 10, 8'h22, 10, 3);
    pulse_base = pulse_total; trk0_at = 4; trk0_arm = 1;
    run_move("R5 recal found", 2'd2, 2, 1, 0, 0, 4, 8'h22, 0, 3);
  endtask

  task automatic t_recal_fail();
    issue(2'd0, 0, 0, 8'hE0, 8'h02);
    check("R1 load 2", int'(ld_ms), 2);
    check("R1 unload zero code", int'(uld_ms), 256);
    check("R1 mode clear", int'(nd), 0);
    run_move("R3 drive3 far", 2'd1, 3, 0, 100, 1, 100, 8'h23, 100, 2);
    run_move("R6 recal limit", 2'd2, 3, 0, 0, 0, 77, 8'h73, 23, 2);
  endtask

  task automatic t_fault();
    pulse_base = pulse_total; fault_at = 0; fault_arm = 1;
    run_move("R7 fault at start", 2'd1, 1, 0, 9, 1, 0, 8'h71, 2, 2);
    pulse_base = pulse_total; fault_at = 2; fault_arm = 1;
    run_move("R7 fault midway", 2'd1, 1, 0, 9, 1, 2, 8'h71, 4, 2);
    run_move("R12 drive0 after all", 2'd1, 0, 0, 0, 0, 0, 8'h20, 0, 2);
  endtask

  task automatic finish_run();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog actual=timeout expected=completion");
    finish_run();
  end

  initial begin
    rst_n = 1'b0; cmd_valid = 1'b0; cmd_op = 2'd0; cmd_unit = 2'd0;
    cmd_head = 1'b0; arg0 = 8'h00; arg1 = 8'h00; ms_tick = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_sense_empty();
    t_specify();
    t_seek_in();
    t_seek_out();
    t_seek_equal();
    t_independent();
    t_recal_ok();
    t_recal_fail();
    t_fault();
    finish_run();
  end
endmodule